// File: doc/BRIEF.md
# Serial Command Frame Port

This block is the serial slave front end of a sixteen-channel output controller. A host drives a clock line, an active-low select line and a data line. The block samples all three with its own system clock and shifts 24-bit command frames in. On the same lines it shifts a 24-bit fault word out. Several of these ports can share one select line in a chain, because the shift path is a plain 24-bit first-in first-out delay from data in to data out.

When select goes low, the port captures the fault word from its fault inputs. When select goes high, it decodes the six most significant bits of the last 24 bits shifted in. A matching opcode writes one of five 16-bit per-output registers or the two global retry bits, or it clears everything. The register contents are exposed as plain outputs. Output gating and fault detection belong to neighbouring logic.

The system clock must run at least four times faster than the serial clock, because every serial line passes through a two-flop synchronizer before its edges are detected.

Top module: `scp_top`

## Requirements
- R1: After the reset pin is asserted, every register output is zero and the data-out enable is low.
- R2: When select falls, the returned word is loaded as follows: bit 23 is the OR of all fault inputs and the overvoltage input, bit 22 is the overvoltage input, bits 21..16 are zero, and bits 15..0 are the per-output fault inputs. A 1 means fault.
- R3: While select is high, serial clock and data are ignored: no register changes and the data-out enable stays low.
- R4: Both directions are most significant bit first. Data in is sampled on serial clock falling edges. Data out changes on serial clock rising edges, and the k-th rising edge presents word bit 24-k.
- R5: Opcodes sit in frame bits 23..18 and data in bits 15..0. The opcodes are: 6'h00 for the on/off register, 6'h04 for open-load enable, 6'h0C for short-fault-protect disable, 6'h01 for PWM enable, and 6'h02 for AND/OR select. Each opcode loads its register from bits 15..0.
- R6: A command takes effect only when select rises. After all 24 bits are shifted but while select is still low, the registers hold their old values.
- R7: Opcode 6'h08 writes the global bits: frame bit 17 sets thermal retry and frame bit 16 sets overvoltage resume.
- R8: Opcode 6'h05 clears every register and both global bits.
- R9: When 48 bits are clocked in one select window, the last 24 bits out equal the first 24 bits in, and the command executed is the last 24 bits in.
- R10: A frame longer than 24 bits is executed using the last 24 bits shifted in.
- R11: A frame with an undefined opcode changes no register.
- R12: Asserting the reset pin after registers have been written returns them all to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset (reset pin and power-on) |
| sclk_i | input | 1 | Serial clock, asynchronous |
| csn_i | input | 1 | Active-low select, asynchronous |
| sdi_i | input | 1 | Serial data in |
| fault_i | input | 16 | Per-output fault flags |
| ovr_i | input | 1 | Overvoltage fault flag |
| sdo_o | output | 1 | Serial data out (0 when disabled) |
| sdo_oe_o | output | 1 | Data-out drive enable; low means high impedance |
| drive_o | output | 16 | On/off register |
| open_det_o | output | 16 | Open-load current enable register |
| sc_off_o | output | 16 | Short-fault-protect disable register |
| pwm_sel_o | output | 16 | PWM enable register |
| or_mode_o | output | 16 | AND/OR select register (1 = OR) |
| therm_retry_o | output | 1 | Thermal retry bit |
| ov_resume_o | output | 1 | Overvoltage resume bit |

## Verification
The assertions assume clean serial timing. Select changes only while the serial clock is low. Data in is stable around each serial clock falling edge. Each serial line level lasts several system clocks. The bench drives every serial half period as at least three system clocks, and changes data in three system clocks after a falling serial edge. It holds the fault inputs steady across each select falling edge, so the captured word is known.

// File: rtl/scp_pkg.sv
package scp_pkg;
  localparam int FRAME_W = 24;
  localparam int N_OUT   = 16;
  localparam int OP_W    = 6;

  typedef struct packed {
    logic [N_OUT-1:0] drive;
    logic [N_OUT-1:0] open_det;
    logic [N_OUT-1:0] sc_off;
    logic [N_OUT-1:0] pwm_sel;
    logic [N_OUT-1:0] or_mode;
    logic             therm_retry;
    logic             ov_resume;
  } cfg_t;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int         W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q, hold_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= RST_VAL[i];
        hold_q <= RST_VAL[i];
      end else begin
        meta_q <= d[i];
        hold_q <= meta_q;
      end
    end
    assign q[i] = hold_q;
  end
endmodule

// File: rtl/scp_shift.sv
module scp_shift #(
  parameter int FW = scp_pkg::FRAME_W,
  parameter int NO = scp_pkg::N_OUT
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [FW-1:0] status,
  input  logic          shift_en,
  input  logic          sdi,
  input  logic          out_en,
  output logic [FW-1:0] sr_q,
  output logic          so_q
);
  logic [FW-1:0] sr_d;
  logic          so_d;

  always_comb begin
    sr_d = sr_q;
    so_d = so_q;
    if (load) begin
      sr_d = status;
      so_d = status[FW-1];
    end else begin
      if (shift_en) sr_d = {sr_q[FW-2:0], sdi};
      if (out_en)   so_d = sr_q[FW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      so_q <= 1'b0;
    end else begin
      sr_q <= sr_d;
      so_q <= so_d;
    end
  end

  p_pad_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> sr_q[FW-3:NO] == '0);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift_en) |=> $stable(sr_q));
  p_so_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !out_en) |=> $stable(so_q));
endmodule

// File: rtl/scp_regs.sv
module scp_regs #(
  parameter int FW = scp_pkg::FRAME_W,
  parameter int NO = scp_pkg::N_OUT,
  parameter int OW = scp_pkg::OP_W,
  parameter logic [OW-1:0] OP_DRIVE = 6'h00,
  parameter logic [OW-1:0] OP_OPEN  = 6'h04,
  parameter logic [OW-1:0] OP_RETRY = 6'h08,
  parameter logic [OW-1:0] OP_SCOFF = 6'h0C,
  parameter logic [OW-1:0] OP_PWM   = 6'h01,
  parameter logic [OW-1:0] OP_ORM   = 6'h02,
  parameter logic [OW-1:0] OP_CLEAR = 6'h05
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exec,
  input  logic [FW-1:0] frame,
  output scp_pkg::cfg_t cfg_q
);
  localparam int OP_LSB = FW - OW;

  logic [OW-1:0]  op;
  logic [NO-1:0]  data;
  scp_pkg::cfg_t  cfg_d;
  logic           known;

  assign op   = frame[FW-1:OP_LSB];
  assign data = frame[NO-1:0];

  always_comb begin
    cfg_d = cfg_q;
    known = 1'b1;
    if (exec) begin
      if      (op == OP_DRIVE) cfg_d.drive    = data;
      else if (op == OP_OPEN)  cfg_d.open_det = data;
      else if (op == OP_SCOFF) cfg_d.sc_off   = data;
      else if (op == OP_PWM)   cfg_d.pwm_sel  = data;
      else if (op == OP_ORM)   cfg_d.or_mode  = data;
      else if (op == OP_RETRY) begin
        cfg_d.therm_retry = frame[NO+1];
        cfg_d.ov_resume   = frame[NO];
      end
      else if (op == OP_CLEAR) cfg_d = '0;
      else known = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  p_exec_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> $stable(cfg_q));
  p_clear_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == OP_CLEAR) |=> cfg_q == '0);
  p_undef_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !known) |=> $stable(cfg_q));
endmodule

// File: rtl/scp_top.sv
module scp_top #(
  parameter int FW = scp_pkg::FRAME_W,
  parameter int NO = scp_pkg::N_OUT,
  parameter int OW = scp_pkg::OP_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sclk_i,
  input  logic          csn_i,
  input  logic          sdi_i,
  input  logic [NO-1:0] fault_i,
  input  logic          ovr_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic [NO-1:0] drive_o,
  output logic [NO-1:0] open_det_o,
  output logic [NO-1:0] sc_off_o,
  output logic [NO-1:0] pwm_sel_o,
  output logic [NO-1:0] or_mode_o,
  output logic          therm_retry_o,
  output logic          ov_resume_o
);
  localparam int PAD_W = FW - 2 - NO;

  logic [2:0] sync_q;
  logic       sclk_s, csn_s, sdi_s;
  logic       sclk_p, csn_p;
  logic       cs_fall, cs_rise, sclk_rise, sclk_fall;
  logic [FW-1:0] status, sr_q;
  logic       so_q;
  scp_pkg::cfg_t cfg;

  scp_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sdi_i, csn_i, sclk_i}), .q(sync_q));

  assign {sdi_s, csn_s, sclk_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= 1'b0;
      csn_p  <= 1'b1;
    end else begin
      sclk_p <= sclk_s;
      csn_p  <= csn_s;
    end
  end

  assign cs_fall   = csn_p & ~csn_s;
  assign cs_rise   = ~csn_p & csn_s;
  assign sclk_rise = ~csn_s & ~sclk_p & sclk_s;
  assign sclk_fall = ~csn_s & sclk_p & ~sclk_s;

  assign status = {(|fault_i) | ovr_i, ovr_i, {PAD_W{1'b0}}, fault_i};

  scp_shift #(.FW(FW), .NO(NO)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(cs_fall), .status(status),
    .shift_en(sclk_fall), .sdi(sdi_s),
    .out_en(sclk_rise),
    .sr_q(sr_q), .so_q(so_q));

  scp_regs #(.FW(FW), .NO(NO), .OW(OW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .exec(cs_rise), .frame(sr_q),
    .cfg_q(cfg));

  assign sdo_oe_o      = ~csn_s;
  assign sdo_o         = ~csn_s & so_q;
  assign drive_o       = cfg.drive;
  assign open_det_o    = cfg.open_det;
  assign sc_off_o      = cfg.sc_off;
  assign pwm_sel_o     = cfg.pwm_sel;
  assign or_mode_o     = cfg.or_mode;
  assign therm_retry_o = cfg.therm_retry;
  assign ov_resume_o   = cfg.ov_resume;

  p_no_drive_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3) |-> !sdo_oe_o);
endmodule

// File: tb/sim_scp_top.sv
`timescale 1ns/1ps
module sim_scp_top;
  logic clk = 1'b0;
  logic rst_n, sclk, csn, sdi, ovr;
  logic [15:0] fault;
  logic sdo, sdo_oe, t_retry, o_res;
  logic [15:0] drive, open_det, sc_off, pwm_sel, or_mode;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] e_drive, e_open, e_scoff, e_pwm, e_or;
  logic        e_tr, e_ov;

  localparam logic [5:0] OP_DRIVE = 6'h00, OP_OPEN = 6'h04, OP_RETRY = 6'h08,
                         OP_SCOFF = 6'h0C, OP_PWM = 6'h01, OP_ORM = 6'h02,
                         OP_CLEAR = 6'h05;

  always #2 clk = ~clk;

  scp_top u0 (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .fault_i(fault), .ovr_i(ovr), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .drive_o(drive), .open_det_o(open_det), .sc_off_o(sc_off),
    .pwm_sel_o(pwm_sel), .or_mode_o(or_mode),
    .therm_retry_o(t_retry), .ov_resume_o(o_res));

  task automatic chk(input string tag, input logic [47:0] got, input logic [47:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [23:0] mk(input logic [5:0] op, input logic [1:0] g, input logic [15:0] d);
    return {op, g, d};
  endfunction

  task automatic model(input logic [23:0] f);
    case (f[23:18])
      OP_DRIVE: e_drive = f[15:0];
      OP_OPEN:  e_open  = f[15:0];
      OP_SCOFF: e_scoff = f[15:0];
      OP_PWM:   e_pwm   = f[15:0];
      OP_ORM:   e_or    = f[15:0];
      OP_RETRY: begin e_tr = f[17]; e_ov = f[16]; end
      OP_CLEAR: begin e_drive = 0; e_open = 0; e_scoff = 0; e_pwm = 0; e_or = 0; e_tr = 0; e_ov = 0; end
      default: ;
    endcase
  endtask

  task automatic chk_regs(input string tag);
    chk({tag, " drive"}, {32'h0, drive}, {32'h0, e_drive});
    chk({tag, " open"},  {32'h0, open_det}, {32'h0, e_open});
    chk({tag, " scoff"}, {32'h0, sc_off}, {32'h0, e_scoff});
    chk({tag, " pwm"},   {32'h0, pwm_sel}, {32'h0, e_pwm});
    chk({tag, " ormode"},{32'h0, or_mode}, {32'h0, e_or});
    chk({tag, " glob"},  {46'h0, t_retry, o_res}, {46'h0, e_tr, e_ov});
  endtask

  task automatic xfer(input logic [47:0] tx, input int n, input bit rel, output logic [47:0] rx);
    rx = '0;
    csn = 1'b0;
    #40;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = tx[i];
      #12 sclk = 1'b1;
      #20 rx = {rx[46:0], sdo};
      #4  sclk = 1'b0;
      #12;
    end
    #24;
    if (rel) begin
      csn = 1'b1;
      #40;
    end
  endtask

  task automatic send(input logic [23:0] f, output logic [47:0] rx);
    xfer({24'h0, f}, 24, 1'b1, rx);
    model(f);
  endtask

  task automatic t_reset;
    chk("R1 drive", {32'h0, drive}, 48'h0);
    chk("R1 oe", {47'h0, sdo_oe}, 48'h0);
    e_drive = 0; e_open = 0; e_scoff = 0; e_pwm = 0; e_or = 0; e_tr = 0; e_ov = 0;
    chk_regs("R1");
  endtask

  task automatic t_writes;
    logic [47:0] rx;
    fault = 16'h0; ovr = 1'b0;
    send(mk(OP_DRIVE, 2'b11, 16'hA5C3), rx);
    chk("R2 clean word", rx & 48'hFFFFFF, 48'h0);
    send(mk(OP_OPEN, 2'b00, 16'h0F0F), rx);
    send(mk(OP_SCOFF, 2'b10, 16'h1234), rx);
    send(mk(OP_PWM, 2'b01, 16'hC001), rx);
    send(mk(OP_ORM, 2'b00, 16'h8421), rx);
    chk_regs("R5");
    send(mk(OP_RETRY, 2'b10, 16'hFFFF), rx);
    chk_regs("R7 thermal");
    send(mk(OP_RETRY, 2'b01, 16'h0000), rx);
    chk_regs("R7 ov");
  endtask

  task automatic t_status;
    logic [47:0] rx;
    fault = 16'h8001; ovr = 1'b1;
    send(mk(OP_OPEN, 2'b00, 16'h00FF), rx);
    chk("R2 R4 word ov", rx & 48'hFFFFFF, {24'h0, 1'b1, 1'b1, 6'b0, 16'h8001});
    fault = 16'h0040; ovr = 1'b0;
    send(mk(OP_DRIVE, 2'b00, 16'h5555), rx);
    chk("R2 R4 word any", rx & 48'hFFFFFF, {24'h0, 1'b1, 1'b0, 6'b0, 16'h0040});
    chk_regs("R4 msb first");
    fault = 16'h0; ovr = 1'b0;
  endtask

  task automatic t_midframe;
    logic [47:0] rx;
    logic [23:0] f;
    f = mk(OP_DRIVE, 2'b00, 16'h3C3C);
    xfer({24'h0, f}, 24, 1'b0, rx);
    chk("R6 before rise", {32'h0, drive}, {32'h0, e_drive});
    csn = 1'b1;
    #40;
    model(f);
    chk("R6 after rise", {32'h0, drive}, {32'h0, e_drive});
  endtask

  task automatic t_idle;
    csn = 1'b1;
    for (int i = 0; i < 30; i++) begin
      sdi = i[0];
      #12 sclk = 1'b1;
      #12 sclk = 1'b0;
    end
    #40;
    chk("R3 oe low", {47'h0, sdo_oe}, 48'h0);
    chk_regs("R3");
  endtask

  task automatic t_integrity;
    logic [47:0] rx;
    logic [23:0] a, b;
    a = 24'h5AC3E1;
    b = mk(OP_PWM, 2'b00, 16'h7E81);
    xfer({a, b}, 48, 1'b1, rx);
    model(b);
    chk("R9 echo", {24'h0, rx[23:0]}, {24'h0, a});
    chk_regs("R9");
  endtask

  task automatic t_long;
    logic [47:0] rx;
    logic [23:0] f;
    f = mk(OP_ORM, 2'b00, 16'hBEEF);
    xfer({18'h0, 6'b101101, f}, 30, 1'b1, rx);
    model(f);
    chk_regs("R10");
  endtask

  task automatic t_undef;
    logic [47:0] rx;
    send(mk(6'h3F, 2'b11, 16'hFFFF), rx);
    send(mk(6'h10, 2'b11, 16'h0000), rx);
    chk_regs("R11");
  endtask

  task automatic t_clear;
    logic [47:0] rx;
    send(mk(OP_RETRY, 2'b11, 16'h0), rx);
    send(mk(OP_CLEAR, 2'b00, 16'hFFFF), rx);
    chk("R8 drive", {32'h0, drive}, 48'h0);
    chk("R8 glob", {46'h0, t_retry, o_res}, 48'h0);
    chk_regs("R8");
  endtask

  task automatic t_pin;
    logic [47:0] rx;
    send(mk(OP_SCOFF, 2'b00, 16'hF00F), rx);
    send(mk(OP_RETRY, 2'b11, 16'h0), rx);
    #1 rst_n = 1'b0;
    #20 rst_n = 1'b1;
    #19;
    model(mk(OP_CLEAR, 2'b00, 16'h0));
    chk("R12 scoff", {32'h0, sc_off}, 48'h0);
    chk_regs("R12");
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; csn = 1'b1; sdi = 1'b0;
    fault = 16'h0; ovr = 1'b0;
    #21 rst_n = 1'b1;
    #20;
    t_reset();
    t_writes();
    t_status();
    t_midframe();
    t_idle();
    t_integrity();
    t_long();
    t_undef();
    t_clear();
    t_pin();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule